// File: doc/BRIEF.md
# Priority-Class Queue Admission Controller

This block sits in front of a shared transaction queue and decides, cycle by cycle, whether an incoming request may claim one of its entries. Each request carries a 4-bit priority that the block folds into one of four classes: low, medium, high and top. Every class has a programmable ceiling on how full the queue may be when a request of that class is admitted. The ceilings are nested, so a request of a higher class can always reach at least as deep into the queue as any class beneath it.

The controller keeps one running count of occupied entries plus a count per class, and updates them in the same cycle that a request is accepted or an entry is released. One queue entry is never offered to external requests; it stays available for internal traffic. Queue storage and scheduling live elsewhere: the owner of the queue reports each freed entry with a one-cycle release pulse that carries the class of the departing request.

Top module: `qos_admission_ctrl`

## Requirements
- R1: The priority is mapped to a class as follows: 15 is class top (code 3), 12 to 14 is class high (code 2), 8 to 11 is class medium (code 1), and 0 to 7 is class low (code 0); the release port uses the same 2-bit codes.
- R2: `req_ready` is high exactly when the current occupancy is below the effective ceiling of the class of `req_prio`; a request is accepted on a rising clock edge where both `req_valid` and `req_ready` are high.
- R3: Occupancy never exceeds DEPTH-1, whatever ceilings are programmed; one entry is always held back from external requests.
- R4: The effective ceiling of the low class is its programmed value; the effective ceiling of each higher class is the larger of its own programmed value and the effective ceiling of the class below; every effective ceiling is then limited to DEPTH-1.
- R5: The `occupancy` output rises by one in the cycle after an edge on which a request is accepted and no valid release occurs.
- R6: A valid release lowers `occupancy` by one on the next cycle; an accept and a valid release on the same edge leave `occupancy` unchanged.
- R7: A release naming a class with no outstanding entries is ignored and does not change `occupancy`.
- R8: After reset `occupancy` is zero.
- R9: Admission compares the total occupancy, from all classes, against the ceiling of the requesting class, so entries held by lower classes count against higher classes and a higher class can keep filling after a lower class is refused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_prio | input | 4 | Priority of the offered request |
| req_ready | output | 1 | The offered request may take an entry |
| rel_valid | input | 1 | One queue entry is freed this cycle |
| rel_class | input | 2 | Class code of the freed entry |
| lim_low | input | CNT_W | Programmed ceiling, low class |
| lim_med | input | CNT_W | Programmed ceiling, medium class |
| lim_high | input | CNT_W | Programmed ceiling, high class |
| lim_top | input | CNT_W | Programmed ceiling, top class |
| occupancy | output | CNT_W | Entries currently allocated (CNT_W = clog2(DEPTH+1)) |

## Verification
A wrong occupancy count shows at the ports within one cycle, because `occupancy` is registered straight from it, and on the next request it moves the point at which `req_ready` drops, so the number of requests accepted from an empty queue differs from the computed ceiling. A lost or duplicated per-class count stays hidden until that class is drained: a stale count lets a release that should be ignored lower the occupancy, or drops a legitimate one. Sweeping every priority against several ceiling sets, including inverted and oversized ones, exposes errors in the class map and in the clamp as a fill depth that does not match.

// File: rtl/qos_adm_pkg.sv
package qos_adm_pkg;

    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        CLS_LOW  = 2'd0,
        CLS_MED  = 2'd1,
        CLS_HIGH = 2'd2,
        CLS_TOP  = 2'd3
    } qos_cls_e;

endpackage

// File: rtl/qos_class_map.sv
module qos_class_map
    import qos_adm_pkg::*;
(
    input  logic [3:0] prio,
    output qos_cls_e   cls
);

    always_comb begin
        if (prio == 4'd15) begin
            cls = CLS_TOP;
        end else if (prio >= 4'd12) begin
            cls = CLS_HIGH;
        end else if (prio >= 4'd8) begin
            cls = CLS_MED;
        end else begin
            cls = CLS_LOW;
        end
    end

endmodule

// File: rtl/qos_limit_clamp.sv
module qos_limit_clamp
    import qos_adm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic [NUM_CLS-1:0][CNT_W-1:0] lim_raw,
    output logic [NUM_CLS-1:0][CNT_W-1:0] lim_eff
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH - 1);

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
        logic [CNT_W-1:0] floor_v;
        logic [CNT_W-1:0] pick_v;
        if (g == 0) begin : g_base
            assign floor_v = '0;
        end else begin : g_nest
            assign floor_v = lim_eff[g-1];
        end
        assign pick_v     = (lim_raw[g] > floor_v) ? lim_raw[g] : floor_v;
        assign lim_eff[g] = (pick_v > CAP) ? CAP : pick_v;
    end

endmodule

// File: rtl/qos_occ_tracker.sv
module qos_occ_tracker
    import qos_adm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  qos_cls_e         acc_cls,
    input  logic             rel,
    input  qos_cls_e         rel_cls,
    output logic [CNT_W-1:0] occ
);

    typedef struct packed {
        logic [NUM_CLS-1:0][CNT_W-1:0] cnt;
        logic [CNT_W-1:0]              occ;
    } trk_t;

    trk_t st_q, st_d;
    logic rel_ok_d;

    always_comb begin
        st_d     = st_q;
        rel_ok_d = rel && (st_q.cnt[rel_cls] != '0);
        for (int g = 0; g < NUM_CLS; g++) begin
            st_d.cnt[g] = st_q.cnt[g]
                        + CNT_W'(acc && (acc_cls == 2'(g)))
                        - CNT_W'(rel_ok_d && (rel_cls == 2'(g)));
        end
        case ({acc, rel_ok_d})
            2'b10:   st_d.occ = st_q.occ + CNT_W'(1);
            2'b01:   st_d.occ = st_q.occ - CNT_W'(1);
            default: st_d.occ = st_q.occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ = st_q.occ;

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= CNT_W'(DEPTH - 1));

    assert_accept_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !rel) |=> (st_q.occ == $past(st_q.occ) + CNT_W'(1)));

    assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rel && st_q.cnt[rel_cls] != '0) |=> $stable(st_q.occ));

    assert_empty_rel_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && rel && st_q.cnt[rel_cls] == '0) |=> $stable(st_q.occ));

endmodule

// File: rtl/qos_admission_ctrl.sv
module qos_admission_ctrl
    import qos_adm_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_prio,
    output logic             req_ready,
    input  logic             rel_valid,
    input  logic [1:0]       rel_class,
    input  logic [CNT_W-1:0] lim_low,
    input  logic [CNT_W-1:0] lim_med,
    input  logic [CNT_W-1:0] lim_high,
    input  logic [CNT_W-1:0] lim_top,
    output logic [CNT_W-1:0] occupancy
);

    qos_cls_e                      req_cls;
    logic [NUM_CLS-1:0][CNT_W-1:0] lim_raw;
    logic [NUM_CLS-1:0][CNT_W-1:0] lim_eff;
    logic                          accept;

    qos_class_map u_map (
        .prio (req_prio),
        .cls  (req_cls)
    );

    assign lim_raw = {lim_top, lim_high, lim_med, lim_low};

    qos_limit_clamp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_clamp (
        .lim_raw (lim_raw),
        .lim_eff (lim_eff)
    );

    assign req_ready = occupancy < lim_eff[req_cls];
    assign accept    = req_valid && req_ready;

    qos_occ_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (accept),
        .acc_cls (req_cls),
        .rel     (rel_valid),
        .rel_cls (qos_cls_e'(rel_class)),
        .occ     (occupancy)
    );

    assert_ready_reserve_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (occupancy < CNT_W'(DEPTH - 1)));

    assert_nested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_eff[1] >= lim_eff[0]) && (lim_eff[2] >= lim_eff[1]) && (lim_eff[3] >= lim_eff[2]));

    assert_top_reach_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cls == CLS_LOW) |-> (occupancy < lim_eff[3]));

endmodule

// File: tb/tb_qos_admission_ctrl.sv
module tb_qos_admission_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [3:0]    req_prio;
    logic          req_ready;
    logic          rel_valid;
    logic [1:0]    rel_class;
    logic [CW-1:0] lim_low, lim_med, lim_high, lim_top;
    logic [CW-1:0] occupancy;

    int total = 0;
    int bad   = 0;
    int cfg [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    qos_admission_ctrl #(.DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_prio  (req_prio),
        .req_ready (req_ready),
        .rel_valid (rel_valid),
        .rel_class (rel_class),
        .lim_low   (lim_low),
        .lim_med   (lim_med),
        .lim_high  (lim_high),
        .lim_top   (lim_top),
        .occupancy (occupancy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cls_of(input int p);
        if (p == 15) return 3;
        if (p >= 12) return 2;
        if (p >= 8)  return 1;
        return 0;
    endfunction

    function automatic int eff_of(input int c);
        int e = 0;
        for (int k = 0; k <= c; k++) begin
            if (cfg[k] > e) e = cfg[k];
            if (e > DEPTH - 1) e = DEPTH - 1;
        end
        return e;
    endfunction

    task automatic set_lim(input int a, input int b, input int c, input int d);
        cfg[0] = a; cfg[1] = b; cfg[2] = c; cfg[3] = d;
        lim_low = CW'(a); lim_med = CW'(b); lim_high = CW'(c); lim_top = CW'(d);
    endtask

    task automatic fill(input int p, output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_prio  = 4'(p);
            #1;
            if (!req_ready) begin
                req_valid = 1'b0;
                break;
            end
            @(posedge clk);
            n++;
        end
        req_valid = 1'b0;
    endtask

    task automatic drain(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rel_valid = 1'b1;
            rel_class = 2'(c);
            @(posedge clk);
        end
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int n;
        int exp;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_prio  = '0;
        rel_valid = 1'b0;
        rel_class = '0;
        set_lim(4, 8, 12, 15);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(occupancy == 0, "R8 reset occupancy", int'(occupancy), 0);
        req_prio = 4'd15;
        #1;
        chk(req_ready == 1'b1, "R2 ready when empty", int'(req_ready), 1);

        // Sweep every priority against several ceiling sets (R1, R2, R3, R4, R5, R6)
        for (int s = 0; s < 4; s++) begin
            case (s)
                0: set_lim(4, 8, 12, 15);
                1: set_lim(10, 6, 3, 20);
                2: set_lim(0, 0, 0, 0);
                default: set_lim(2, 5, 5, 9);
            endcase
            for (int p = 0; p < 16; p++) begin
                exp = eff_of(cls_of(p));
                fill(p, n);
                chk(n == exp, "R1 R2 R4 fill depth for priority", n, exp);
                @(negedge clk);
                chk(int'(occupancy) == exp, "R5 occupancy after fill", int'(occupancy), exp);
                chk(int'(occupancy) <= DEPTH - 1, "R3 reserved entry", int'(occupancy), DEPTH - 1);
                drain(cls_of(p), n);
                chk(occupancy == 0, "R6 occupancy after drain", int'(occupancy), 0);
            end
        end

        // Nested pools with mixed classes (R9, R3)
        set_lim(4, 8, 12, 20);
        fill(0, n);
        chk(n == 4, "R9 low class stops at its ceiling", n, 4);
        fill(8, n);
        chk(n == 4, "R9 medium continues above low", n, 4);
        fill(12, n);
        chk(n == 4, "R9 high continues above medium", n, 4);
        fill(15, n);
        chk(n == 3, "R9 R3 top stops at DEPTH-1", n, 3);
        @(negedge clk);
        chk(int'(occupancy) == DEPTH - 1, "R3 occupancy at cap", int'(occupancy), DEPTH - 1);
        req_prio = 4'd15;
        #1;
        chk(req_ready == 1'b0, "R3 top refused at cap", int'(req_ready), 0);
        drain(0, 4);
        drain(1, 4);
        drain(2, 4);
        drain(3, 3);
        chk(occupancy == 0, "R6 mixed drain", int'(occupancy), 0);

        // Simultaneous accept and release (R6)
        fill(0, n);
        drain(0, 2);
        chk(occupancy == 2, "R6 partial drain", int'(occupancy), 2);
        @(negedge clk);
        req_valid = 1'b1;
        req_prio  = 4'd0;
        rel_valid = 1'b1;
        rel_class = 2'd0;
        #1;
        chk(req_ready == 1'b1, "R2 ready below ceiling", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rel_valid = 1'b0;
        chk(occupancy == 2, "R6 accept and release together", int'(occupancy), 2);

        // Release of a class with nothing outstanding (R7)
        @(negedge clk);
        rel_valid = 1'b1;
        rel_class = 2'd3;
        @(posedge clk);
        @(negedge clk);
        rel_valid = 1'b0;
        chk(occupancy == 2, "R7 release of empty class ignored", int'(occupancy), 2);
        drain(0, 2);
        chk(occupancy == 0, "R6 drain to empty", int'(occupancy), 0);
        drain(2, 1);
        chk(occupancy == 0, "R7 release on empty queue ignored", int'(occupancy), 0);

        // Single accept timing (R5)
        @(negedge clk);
        req_valid = 1'b1;
        req_prio  = 4'd9;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(occupancy == 1, "R5 one accept visible next cycle", int'(occupancy), 1);
        drain(1, 1);
        chk(occupancy == 0, "R6 single release", int'(occupancy), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule